// File: doc/BRIEF.md
# Accumulator ALU Instruction Executor

This block is the execution core of a small accumulator-based 8-bit controller. Each instruction cycle it takes one 13-bit word from program memory, decodes it and updates the accumulator, a banked register file and the zero, carry and digit-carry flags. Nine operations are decoded: no-operation, decimal adjust, accumulator clear, register clear, register store, two subtractions, decrement-into-accumulator and a table jump that adds the accumulator to the program counter. Every other word is executed as a no-operation.

The 10-bit program counter is visible as register address 2, so any instruction that writes that address, and the table jump, redirects the fetch stream. The block then raises `stall` for the next instruction cycle, discards the word fetched during it and holds the counter. Register addresses 0x00 to 0x0F form one common window. Addresses 0x10 to 0x3F are banked, and the upper two bits of register 4 select the bank. The block feeds `pcOut` to program memory and expects the addressed word on `instrWord` for the whole instruction cycle.

Top module: `mcu_alu_exec`

## Requirements
- R1: One instruction cycle is two clock periods, counted from reset release. The accumulator, flags and program counter change only at the second rising edge of each cycle and stay constant at the first.
- R2: After reset the counter, accumulator, flags, stall and all registers are zero. Each executed instruction that does not write the counter advances it by one, wrapping at 10 bits.
- R3: A write to register address 2 (store 0x040|r, clear 0x0C0|r, subtract-into-register 0x140|r) or a table jump replaces counter bits 7:0, keeps bits 9:8 and raises `stall` for exactly the next instruction cycle. In that cycle the fetched word has no effect and the counter holds.
- R4: Table jump (0x020) sets counter bits 7:0 to their old value plus A, modulo 256. C is the carry out of bit 7, DC is the carry out of bit 3, and Z reports a zero low byte.
- R5: Store 0x040|r (r = bits 5:0) copies A into register r and leaves all flags unchanged.
- R6: Clear 0x0C0|r writes 0 to register r. Clear-accumulator 0x080 writes 0 to A. Both set Z and leave C and DC unchanged.
- R7: Subtract 0x100|r writes R−A to A, and subtract 0x140|r writes R−A to register r. C = 1 when R ≥ A, DC = 1 when R[3:0] ≥ A[3:0], and Z = 1 for a zero result.
- R8: Decrement 0x180|r writes R−1 to A and updates only Z.
- R9: Decimal adjust 0x001 adds 0x06 when A[3:0] > 9 or DC = 1. It adds 0x60 when A > 0x99 or C = 1. C becomes 1 exactly when 0x60 was added, and Z and DC are unchanged.
- R10: Addresses 0x00 to 0x0F name the same storage in every bank. Addresses 0x10 to 0x3F name separate storage for each value of register 4 bits 7:6.
- R11: Word 0x000 and every undecoded word change nothing except advancing the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two periods per instruction cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWord | input | 13 | Instruction fetched at `pcOut`, held for the whole cycle |
| pcOut | output | 10 | Program counter (register address 2) |
| accOut | output | 8 | Accumulator |
| zFlag | output | 1 | Zero flag |
| cFlag | output | 1 | Carry / no-borrow flag |
| dcFlag | output | 1 | Digit carry / nibble no-borrow flag |
| stall | output | 1 | High during the discarded cycle after a counter write |

## Verification
The bench goes after the subtraction boundaries: equal operands, a borrow from the top, and a borrow only from the low nibble. A design with an inverted borrow sense, or with DC tested on the wrong nibble, reports flipped C or DC there. Counter writes are checked with a live instruction placed in the stall slot. A design that executes that word corrupts the accumulator, and one that replaces the full counter loses bits 9:8. Bank switching is tested by reading the same banked address under two banks and a common address under both, which exposes a missing or misapplied bank index. Decimal adjust is driven from both flag states to catch a design that ignores C or DC.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;
  localparam int DATA_W   = 8;
  localparam int PC_W     = 10;
  localparam int INSTR_W  = 13;
  localparam int RADDR_W  = 6;
  localparam int BANK_W   = 2;
  localparam int COMMON_N = 16;
  localparam int BANK_N   = 1 << BANK_W;
  localparam int BANKED_N = (1 << RADDR_W) - COMMON_N;
  localparam int CIDX_W   = $clog2(COMMON_N);
  localparam logic [RADDR_W-1:0] PC_ADDR   = RADDR_W'(2);
  localparam logic [RADDR_W-1:0] BANK_ADDR = RADDR_W'(4);

  typedef enum logic [3:0] {
    OP_NOP, OP_DAA, OP_TBL, OP_CLRA, OP_MOV,
    OP_CLR, OP_SUBA, OP_SUBR, OP_DECA
  } aluOp_e;

  typedef struct packed {
    logic               advance;  // last edge of the instruction cycle
    logic               fire;     // execute the decoded word at that edge
    logic               pcLoad;   // executed word writes the counter
    aluOp_e             op;
    logic [RADDR_W-1:0] addr;
  } ctrl_t;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import alu_exec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrl_t              ctrl,
  output logic               stall
);
  logic   phaseQ;
  logic   stallQ;
  aluOp_e op;
  logic   writesReg;

  always_comb begin
    op = OP_NOP;
    if (instrWord == INSTR_W'(13'h0001))      op = OP_DAA;
    else if (instrWord == INSTR_W'(13'h0020)) op = OP_TBL;
    else if (instrWord == INSTR_W'(13'h0080)) op = OP_CLRA;
    else begin
      case (instrWord[INSTR_W-1:RADDR_W])
        7'b0000001: op = OP_MOV;
        7'b0000011: op = OP_CLR;
        7'b0000100: op = OP_SUBA;
        7'b0000101: op = OP_SUBR;
        7'b0000110: op = OP_DECA;
        default:    op = OP_NOP;
      endcase
    end
  end

  assign writesReg = (op == OP_MOV) || (op == OP_CLR) || (op == OP_SUBR);

  always_comb begin
    ctrl.advance = phaseQ;
    ctrl.fire    = phaseQ && !stallQ;
    ctrl.op      = op;
    ctrl.addr    = instrWord[RADDR_W-1:0];
    ctrl.pcLoad  = (op == OP_TBL) || (writesReg && instrWord[RADDR_W-1:0] == PC_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
      stallQ <= 1'b0;
    end else begin
      phaseQ <= !phaseQ;
      if (phaseQ) stallQ <= ctrl.fire && ctrl.pcLoad;
    end
  end

  assign stall = stallQ;

  // R3: a counter write opens exactly one discarded slot
  p_stall_after_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && ctrl.pcLoad) |=> stallQ);
  p_stall_one_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stallQ && phaseQ) |=> !stallQ);
  p_stall_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stallQ && !phaseQ) |=> stallQ);
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import alu_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  output logic [PC_W-1:0]   pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic              zFlag,
  output logic              cFlag,
  output logic              dcFlag
);
  logic [PC_W-1:0]   pcQ;
  logic [DATA_W-1:0] accQ;
  logic              zQ, cQ, dcQ;
  logic [DATA_W-1:0] commonRegs [COMMON_N];
  logic [DATA_W-1:0] bankedRegs [BANK_N][BANKED_N];

  logic [BANK_W-1:0]  bankSel;
  logic               isCommon;
  logic               isPcAddr;
  logic [CIDX_W-1:0]  cIdx;
  logic [RADDR_W-1:0] bIdx;
  logic [DATA_W-1:0]  srcVal;

  assign bankSel  = commonRegs[BANK_ADDR[CIDX_W-1:0]][DATA_W-1 -: BANK_W];
  assign isCommon = ctrl.addr < RADDR_W'(COMMON_N);
  assign isPcAddr = ctrl.addr == PC_ADDR;
  assign cIdx     = ctrl.addr[CIDX_W-1:0];
  assign bIdx     = ctrl.addr - RADDR_W'(COMMON_N);

  always_comb begin
    if (isPcAddr)      srcVal = pcQ[DATA_W-1:0];
    else if (isCommon) srcVal = commonRegs[cIdx];
    else               srcVal = bankedRegs[bankSel][bIdx];
  end

  // ALU
  logic [DATA_W-1:0] aluRes, adj;
  logic [DATA_W:0]   wide;
  logic [4:0]        nib;
  logic              wrAcc, wrReg, updZ, updC, updDc;
  logic              newC, newDc, lowAdj, highAdj;

  always_comb begin
    aluRes = '0; wide = '0; nib = '0; adj = '0;
    wrAcc = 1'b0; wrReg = 1'b0; updZ = 1'b0; updC = 1'b0; updDc = 1'b0;
    newC = cQ; newDc = dcQ; lowAdj = 1'b0; highAdj = 1'b0;
    case (ctrl.op)
      OP_DAA: begin
        lowAdj  = (accQ[3:0] > 4'd9) || dcQ;
        highAdj = (accQ > 8'h99) || cQ;
        if (lowAdj)  adj[3:0] = 4'h6;
        if (highAdj) adj[7:4] = 4'h6;
        aluRes = accQ + adj;
        newC = highAdj; updC = 1'b1; wrAcc = 1'b1;
      end
      OP_TBL: begin
        wide = {1'b0, pcQ[DATA_W-1:0]} + {1'b0, accQ};
        nib  = {1'b0, pcQ[3:0]} + {1'b0, accQ[3:0]};
        aluRes = wide[DATA_W-1:0];
        newC = wide[DATA_W]; newDc = nib[4];
        updZ = 1'b1; updC = 1'b1; updDc = 1'b1;
      end
      OP_CLRA: begin aluRes = '0; wrAcc = 1'b1; updZ = 1'b1; end
      OP_CLR:  begin aluRes = '0; wrReg = 1'b1; updZ = 1'b1; end
      OP_MOV:  begin aluRes = accQ; wrReg = 1'b1; end
      OP_SUBA, OP_SUBR: begin
        wide = {1'b0, srcVal} - {1'b0, accQ};
        aluRes = wide[DATA_W-1:0];
        newC  = !wide[DATA_W];
        newDc = srcVal[3:0] >= accQ[3:0];
        updZ = 1'b1; updC = 1'b1; updDc = 1'b1;
        if (ctrl.op == OP_SUBA) wrAcc = 1'b1;
        else                    wrReg = 1'b1;
      end
      OP_DECA: begin
        aluRes = srcVal - DATA_W'(1);
        wrAcc = 1'b1; updZ = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0; accQ <= '0; zQ <= 1'b0; cQ <= 1'b0; dcQ <= 1'b0;
      for (int i = 0; i < COMMON_N; i++) commonRegs[i] <= '0;
      for (int b = 0; b < BANK_N; b++)
        for (int j = 0; j < BANKED_N; j++) bankedRegs[b][j] <= '0;
    end else if (ctrl.fire) begin
      if (wrAcc) accQ <= aluRes;
      if (updZ)  zQ   <= (aluRes == '0);
      if (updC)  cQ   <= newC;
      if (updDc) dcQ  <= newDc;
      if (wrReg && !isPcAddr) begin
        if (isCommon) commonRegs[cIdx] <= aluRes;
        else          bankedRegs[bankSel][bIdx] <= aluRes;
      end
      if (ctrl.pcLoad) pcQ <= {pcQ[PC_W-1:DATA_W], aluRes};
      else             pcQ <= pcQ + PC_W'(1);
    end
  end

  assign pcOut = pcQ; assign accOut = accQ;
  assign zFlag = zQ;  assign cFlag = cQ; assign dcFlag = dcQ;

  // R1: architectural state only moves at the closing edge of a cycle
  p_hold_first_edge_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.advance |=> ($stable(accQ) && $stable(pcQ) && $stable({zQ, cQ, dcQ})));
  // R2: ordinary instructions step the counter
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && !ctrl.pcLoad) |=> (pcQ == PC_W'($past(pcQ) + PC_W'(1))));
  // R3: discarded slot leaves the counter alone
  p_pc_hold_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && !ctrl.fire) |=> $stable(pcQ));
  // R3, R4: upper counter bits survive every counter write
  p_pc_upper_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && ctrl.pcLoad) |=> (pcQ[PC_W-1:DATA_W] == $past(pcQ[PC_W-1:DATA_W])));
  // R5: store leaves flags untouched
  p_mov_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && ctrl.op == OP_MOV) |=> $stable({zQ, cQ, dcQ}));
  // R8: decrement touches only Z
  p_deca_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && ctrl.op == OP_DECA) |=> $stable({cQ, dcQ}));
  // R9: decimal adjust keeps Z and DC
  p_daa_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.fire && ctrl.op == OP_DAA) |=> $stable({zQ, dcQ}));
endmodule

// File: rtl/mcu_alu_exec.sv
module mcu_alu_exec
  import alu_exec_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  output logic [PC_W-1:0]    pcOut,
  output logic [DATA_W-1:0]  accOut,
  output logic               zFlag,
  output logic               cFlag,
  output logic               dcFlag,
  output logic               stall
);
  ctrl_t ctrl;

  exec_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .ctrl(ctrl), .stall(stall)
  );

  exec_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pcOut(pcOut), .accOut(accOut),
    .zFlag(zFlag), .cFlag(cFlag), .dcFlag(dcFlag)
  );
endmodule

// File: tb/test_mcu_alu_exec.sv
`timescale 1ns/1ps
module test_mcu_alu_exec;
  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] instrWord;
  logic [9:0]  pcOut;
  logic [7:0]  accOut;
  logic        zFlag, cFlag, dcFlag, stall;

  mcu_alu_exec i_mcu_alu_exec (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .pcOut(pcOut),
    .accOut(accOut), .zFlag(zFlag), .cFlag(cFlag), .dcFlag(dcFlag), .stall(stall)
  );

  always #5 clk = ~clk;

  localparam logic [5:0] TR = 6'h0E;  // scratch
  localparam logic [5:0] ZR = 6'h0F;  // always zero
  localparam logic [5:0] WR = 6'h0D;  // throwaway
  function automatic logic [12:0] opMov (logic [5:0] r); return 13'h040 | r; endfunction
  function automatic logic [12:0] opClr (logic [5:0] r); return 13'h0C0 | r; endfunction
  function automatic logic [12:0] opSubA(logic [5:0] r); return 13'h100 | r; endfunction
  function automatic logic [12:0] opSubR(logic [5:0] r); return 13'h140 | r; endfunction
  function automatic logic [12:0] opDec (logic [5:0] r); return 13'h180 | r; endfunction

  int nChecks = 0;
  int nFails  = 0;
  logic [9:0] expPc;
  bit done = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [12:0] w);
    instrWord = w;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask
  task automatic run(logic [12:0] w);
    cyc(w); expPc = expPc + 10'd1;
  endtask
  task automatic setReg(logic [5:0] r, int v);
    run(opClr(r)); run(opDec(ZR));
    for (int i = 0; i < v; i++) run(opSubR(r));
  endtask
  task automatic loadA(int v);
    setReg(TR, v); run(13'h080); run(opSubA(TR));
  endtask
  task automatic readReg(logic [5:0] r, output logic [7:0] v);
    run(13'h080); run(opSubA(r)); v = accOut;
  endtask
  task automatic clearCarry;
    run(opClr(WR)); run(opSubR(WR));
  endtask

  task automatic t_reset;
    chk("R2 reset pc", 16'(pcOut), 16'h0);
    chk("R2 reset acc", 16'(accOut), 16'h0);
    chk("R2 reset flags", 16'({zFlag, cFlag, dcFlag}), 16'h0);
    chk("R3 reset stall", 16'(stall), 16'h0);
  endtask

  task automatic t_timing;
    loadA(8'h3C);
    chk("R2 pc step count", 16'(pcOut), 16'(expPc));
    instrWord = 13'h080;
    @(posedge clk); @(negedge clk);
    chk("R1 acc held at first edge", 16'(accOut), 16'h3C);
    chk("R1 pc held at first edge", 16'(pcOut), 16'(expPc));
    @(posedge clk); @(negedge clk);
    expPc = expPc + 10'd1;
    chk("R1 acc updated at second edge", 16'(accOut), 16'h0);
    chk("R1 pc updated at second edge", 16'(pcOut), 16'(expPc));
  endtask

  task automatic t_nop;
    logic [2:0] f;
    loadA(8'h5A); f = {zFlag, cFlag, dcFlag};
    run(13'h0000);
    chk("R11 nop acc", 16'(accOut), 16'h5A);
    chk("R11 nop flags", 16'({zFlag, cFlag, dcFlag}), 16'(f));
    chk("R11 nop pc", 16'(pcOut), 16'(expPc));
    run(13'h1FFF);
    chk("R11 undecoded acc", 16'(accOut), 16'h5A);
    chk("R11 undecoded flags", 16'({zFlag, cFlag, dcFlag}), 16'(f));
    chk("R11 undecoded pc", 16'(pcOut), 16'(expPc));
  endtask

  task automatic t_mov;
    logic [2:0] f; logic [7:0] v;
    loadA(8'h77); f = {zFlag, cFlag, dcFlag};
    run(opMov(6'h11));
    chk("R5 mov flags", 16'({zFlag, cFlag, dcFlag}), 16'(f));
    readReg(6'h11, v);
    chk("R5 mov stored", 16'(v), 16'h77);
  endtask

  task automatic t_clr;
    logic [1:0] f; logic [7:0] v;
    setReg(6'h12, 8'h44); f = {cFlag, dcFlag};
    run(opClr(6'h12));
    chk("R6 clr Z", 16'(zFlag), 16'h1);
    chk("R6 clr C DC kept", 16'({cFlag, dcFlag}), 16'(f));
    readReg(6'h12, v);
    chk("R6 clr value", 16'(v), 16'h0);
    loadA(8'h05);
    run(13'h080);
    chk("R6 clra acc", 16'(accOut), 16'h0);
    chk("R6 clra flags", 16'({zFlag, cFlag, dcFlag}), 16'b111);
  endtask

  task automatic subCase(logic [7:0] rv, logic [7:0] av, bit toA);
    logic [7:0] exp, v; logic [2:0] ef;
    exp = rv - av;
    ef = {exp == 8'h0, rv >= av, rv[3:0] >= av[3:0]};
    setReg(6'h13, rv); loadA(av);
    run(toA ? opSubA(6'h13) : opSubR(6'h13));
    chk("R7 sub flags", 16'({zFlag, cFlag, dcFlag}), 16'(ef));
    if (toA) chk("R7 sub into A", 16'(accOut), 16'(exp));
    else begin
      readReg(6'h13, v);
      chk("R7 sub into R", 16'(v), 16'(exp));
    end
  endtask

  task automatic t_deca;
    logic [1:0] f;
    setReg(6'h14, 1); f = {cFlag, dcFlag};
    run(opDec(6'h14));
    chk("R8 deca to zero", 16'({accOut, zFlag}), 16'({8'h00, 1'b1}));
    chk("R8 deca C DC kept", 16'({cFlag, dcFlag}), 16'(f));
    f = {cFlag, dcFlag};
    run(opDec(ZR));
    chk("R8 deca wrap", 16'({accOut, zFlag}), 16'({8'hFF, 1'b0}));
    chk("R8 deca wrap C DC kept", 16'({cFlag, dcFlag}), 16'(f));
  endtask

  task automatic daaCase(logic [7:0] a, bit clr);
    logic lo, hi; logic [7:0] exp; logic [1:0] zd;
    loadA(a); if (clr) clearCarry;
    lo = (a[3:0] > 4'd9) || dcFlag;
    hi = (a > 8'h99) || cFlag;
    exp = a + (lo ? 8'h06 : 8'h00) + (hi ? 8'h60 : 8'h00);
    zd = {zFlag, dcFlag};
    run(13'h001);
    chk("R9 daa acc", 16'(accOut), 16'(exp));
    chk("R9 daa C", 16'(cFlag), 16'(hi));
    chk("R9 daa Z DC kept", 16'({zFlag, dcFlag}), 16'(zd));
  endtask

  task automatic t_bank;
    logic [7:0] v;
    setReg(6'h10, 8'h11);
    setReg(6'h04, 8'h40);
    readReg(6'h10, v);
    chk("R10 bank1 separate", 16'(v), 16'h00);
    setReg(6'h10, 8'h22);
    setReg(6'h0C, 8'h5A);
    setReg(6'h04, 8'h00);
    readReg(6'h10, v);
    chk("R10 bank0 kept", 16'(v), 16'h11);
    readReg(6'h0C, v);
    chk("R10 common shared", 16'(v), 16'h5A);
  endtask

  task automatic t_pcwrite;
    logic [9:0] p; logic [7:0] a; logic [8:0] s; logic [4:0] n;
    loadA(8'hF0); p = expPc;
    cyc(opMov(6'h02)); expPc = {p[9:8], 8'hF0};
    chk("R3 mov pc", 16'(pcOut), 16'(expPc));
    chk("R3 stall raised", 16'(stall), 16'h1);
    cyc(13'h080);
    chk("R3 slot discarded acc", 16'(accOut), 16'hF0);
    chk("R3 slot pc held", 16'(pcOut), 16'(expPc));
    chk("R3 stall dropped", 16'(stall), 16'h0);
    run(13'h000);
    chk("R3 pc resumes", 16'(pcOut), 16'(expPc));
    for (int k = 0; k < 2; k++) begin
      loadA(k == 0 ? 8'hFF : 8'h01); a = accOut; p = expPc;
      s = {1'b0, p[7:0]} + {1'b0, a}; n = {1'b0, p[3:0]} + {1'b0, a[3:0]};
      cyc(13'h020); expPc = {p[9:8], s[7:0]};
      chk("R4 tbl pc", 16'(pcOut), 16'(expPc));
      chk("R4 tbl flags", 16'({zFlag, cFlag, dcFlag}), 16'({s[7:0] == 8'h0, s[8], n[4]}));
      chk("R3 tbl stall", 16'(stall), 16'h1);
      cyc(13'h000);
      chk("R3 tbl slot pc", 16'(pcOut), 16'(expPc));
    end
    p = expPc;
    cyc(opClr(6'h02)); expPc = {p[9:8], 8'h00};
    chk("R3 clr pc", 16'(pcOut), 16'(expPc));
    cyc(13'h000);
    loadA(8'h03); p = expPc;
    cyc(opSubR(6'h02)); expPc = {p[9:8], p[7:0] - 8'h03};
    chk("R3 sub pc", 16'(pcOut), 16'(expPc));
    chk("R3 sub stall", 16'(stall), 16'h1);
    cyc(13'h000);
    chk("R3 sub slot pc", 16'(pcOut), 16'(expPc));
  endtask

  initial begin
    rstN = 1'b0; instrWord = 13'h0; expPc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_timing;
    t_nop;
    t_mov;
    t_clr;
    subCase(8'h53, 8'h35, 1'b1);
    subCase(8'h20, 8'h30, 1'b1);
    subCase(8'h44, 8'h44, 1'b0);
    subCase(8'h10, 8'h8F, 1'b0);
    t_deca;
    daaCase(8'h1A, 1'b1);
    daaCase(8'h9B, 1'b1);
    daaCase(8'h12, 1'b0);
    t_bank;
    t_pcwrite;
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule